// File: doc/BRIEF.md
# Arm Cell Charge Rotation Controller

This block brings the storage capacitors of one converter arm from the voltage they reach passively on the DC bus up to a chosen target voltage. When the pole is first connected, the cells share the pole voltage evenly. To push them higher, the controller switches in only a whole number of cells at a time, so that each inserted cell sees a larger share of the bus. The number inserted is the floor or the ceiling of pole voltage over target. The controller picks one of these two counts at every rotation tick, and on each tick it inserts the least-charged cells. It also releases an inrush-limiting resistor once the arm is nearly charged.

Software or a sequencer sets the target, holds `chg_en` high for the whole charging run, and drops it to stop. At the start of a run a shift-subtract divider works out the two counts from the pole voltage and the target. After that a millisecond tick, derived from a clock-frequency parameter, paces every re-evaluation.

The state machine has four states:
- `ST_IDLE` goes to `ST_DIV` when enabled.
- `ST_DIV` goes to `ST_WAIT` when the divider reports done.
- `ST_WAIT` goes to `ST_ROTATE` on a tick.
- `ST_ROTATE` goes back to `ST_WAIT` after one cycle.

From any state, a low `chg_en` returns the machine to `ST_IDLE`.

Top module: `cell_charge_rotator`

## Requirements
- R1: While reset is asserted, and afterwards until enabled, `insert_mask` is all zeros and `bypass_res` is low.
- R2: At each rotation the number of set mask bits equals the low count floor(v_pole/v_target) when the sum of all cell voltages is strictly greater than N_CELLS*v_target, and otherwise equals the high count, ceil(v_pole/v_target).
- R3: When v_pole is an exact multiple of v_target, the high and low counts are equal, and the two counts never differ by more than one.
- R4: Both counts are clamped to N_CELLS; if the quotient is N_CELLS or more, every mask bit is set.
- R5: Mask bit i belongs to cell i, which occupies v_cell[i*VW +: VW]. The cells inserted are those with the lowest voltages, and equal voltages are ranked by lower index first.
- R6: The mask changes only at a rotation. Rotations follow the first tick after the divide completes and then occur every CLK_HZ/TICK_HZ cycles.
- R7: `bypass_res` goes high at a rotation where 10*sum >= 9*N_CELLS*v_target, that is, an average of 90% of target. It then stays high until `chg_en` falls.
- R8: A low `chg_en` clears the mask, the bypass and both counts at the next clock edge.
- R9: The counts come from the v_pole value present when the run starts. Later changes to v_pole do not alter the inserted count until the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chg_en | input | 1 | Run command, held high while charging |
| v_cell | input | N_CELLS*VW | Packed per-cell voltage samples, cell i at bits i*VW |
| v_pole | input | DW | DC pole voltage |
| v_target | input | VW | Target cell voltage |
| insert_mask | output | N_CELLS | One bit per cell, 1 = inserted |
| bypass_res | output | 1 | Command to short the charging resistor |

## Verification
The properties assume that v_target is nonzero, so the divider yields a meaningful quotient. They also assume the voltage samples fit within VW bits. In addition, they assume v_target stays fixed during a run, because the count is tied to the value present at the start. The stimulus changes v_target and v_pole only while `chg_en` is low, apart from the one directed case that moves v_pole mid-run to show it is ignored. Every vector uses a nonzero target.

// File: rtl/cellchg_pkg.sv
package cellchg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIV,
        ST_WAIT,
        ST_ROTATE
    } chg_state_e;
endpackage

// File: rtl/cellchg_tick.sv
module cellchg_tick #(
    parameter int unsigned DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (cnt_q == PW'(DIV - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PW'(1);
        end
    end

    assign tick = en && (cnt_q == PW'(DIV - 1));
endmodule

// File: rtl/cellchg_divider.sv
module cellchg_divider #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [DW-1:0] quo,
    output logic [DW-1:0] rem
);
    localparam int unsigned KW = $clog2(DW + 1);

    logic [DW-1:0] quo_q, rem_q, div_q;
    logic [KW-1:0] cnt_q;
    logic          busy_q;
    logic [DW:0]   trial;
    logic          fits;

    always_comb begin
        trial = {rem_q, quo_q[DW-1]};
        fits  = trial >= {1'b0, div_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q  <= '0;
            rem_q  <= '0;
            div_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                quo_q  <= dividend;
                rem_q  <= '0;
                div_q  <= divisor;
                cnt_q  <= KW'(DW);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (fits) begin
                    rem_q <= DW'(trial - {1'b0, div_q});
                    quo_q <= {quo_q[DW-2:0], 1'b1};
                end else begin
                    rem_q <= DW'(trial);
                    quo_q <= {quo_q[DW-2:0], 1'b0};
                end
                cnt_q <= cnt_q - KW'(1);
                if (cnt_q == KW'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign quo = quo_q;
    assign rem = rem_q;
endmodule

// File: rtl/cellchg_select.sv
module cellchg_select #(
    parameter int unsigned N  = 10,
    parameter int unsigned VW = 12,
    parameter int unsigned CW = 4
) (
    input  logic [N*VW-1:0] v_cell,
    input  logic [CW-1:0]   count,
    output logic [N-1:0]    mask
);
    for (genvar i = 0; i < N; i++) begin : g_rank
        logic [CW-1:0] rank;
        always_comb begin
            rank = '0;
            for (int j = 0; j < N; j++) begin
                if (j != i) begin
                    if ((v_cell[j*VW +: VW] < v_cell[i*VW +: VW]) ||
                        ((v_cell[j*VW +: VW] == v_cell[i*VW +: VW]) && (j < i))) begin
                        rank = rank + CW'(1);
                    end
                end
            end
        end
        assign mask[i] = rank < count;
    end
endmodule

// File: rtl/cell_charge_rotator.sv
module cell_charge_rotator
    import cellchg_pkg::*;
#(
    parameter int unsigned N_CELLS = 10,
    parameter int unsigned VW      = 12,
    parameter int unsigned DW      = 16,
    parameter int unsigned CLK_HZ  = 125_000_000,
    parameter int unsigned TICK_HZ = 1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chg_en,
    input  logic [N_CELLS*VW-1:0] v_cell,
    input  logic [DW-1:0]        v_pole,
    input  logic [VW-1:0]        v_target,
    output logic [N_CELLS-1:0]   insert_mask,
    output logic                 bypass_res
);
    localparam int unsigned TICK_DIV = CLK_HZ / TICK_HZ;
    localparam int unsigned CW       = $clog2(N_CELLS + 1);
    localparam int unsigned SW       = VW + $clog2(N_CELLS);
    localparam int unsigned BW       = SW + 4;

    chg_state_e st_q, st_d;
    logic tick, div_go, div_done, rot_now;
    logic [DW-1:0] quo, rem;
    logic [CW-1:0] hi_q, lo_q, sel_cnt;
    logic [N_CELLS-1:0] sel_mask;
    logic [SW-1:0] sum_v, nt_v;
    logic above, reach;

    cellchg_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(chg_en), .tick(tick)
    );

    cellchg_divider #(.DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go),
        .dividend(v_pole), .divisor(DW'(v_target)),
        .done(div_done), .quo(quo), .rem(rem)
    );

    cellchg_select #(.N(N_CELLS), .VW(VW), .CW(CW)) u_sel (
        .v_cell(v_cell), .count(sel_cnt), .mask(sel_mask)
    );

    // Arm sum against N*target replaces an average.
    always_comb begin
        sum_v = '0;
        for (int i = 0; i < N_CELLS; i++) begin
            sum_v = sum_v + SW'(v_cell[i*VW +: VW]);
        end
        nt_v    = SW'(N_CELLS) * SW'(v_target);
        above   = sum_v > nt_v;
        reach   = (BW'(sum_v) * BW'(10)) >= (BW'(nt_v) * BW'(9));
        sel_cnt = above ? lo_q : hi_q;
    end

    assign div_go  = (st_q == ST_IDLE) && chg_en;
    assign rot_now = (st_q == ST_ROTATE);

    always_comb begin
        st_d = st_q;
        if (!chg_en) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:   st_d = ST_DIV;
                ST_DIV:    if (div_done) st_d = ST_WAIT;
                ST_WAIT:   if (tick) st_d = ST_ROTATE;
                ST_ROTATE: st_d = ST_WAIT;
                default:   st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            insert_mask <= '0;
            bypass_res  <= 1'b0;
            hi_q        <= '0;
            lo_q        <= '0;
        end else if (!chg_en) begin
            insert_mask <= '0;
            bypass_res  <= 1'b0;
            hi_q        <= '0;
            lo_q        <= '0;
        end else begin
            if ((st_q == ST_DIV) && div_done) begin
                if (quo >= DW'(N_CELLS)) begin
                    lo_q <= CW'(N_CELLS);
                    hi_q <= CW'(N_CELLS);
                end else begin
                    lo_q <= CW'(quo);
                    hi_q <= CW'(quo) + CW'(rem != '0);
                end
            end
            if (rot_now) begin
                insert_mask <= sel_mask;
                if (reach) bypass_res <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cell_charge_rotator_chk.sv
module cell_charge_rotator_chk #(
    parameter int unsigned N  = 10,
    parameter int unsigned CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [N-1:0]  mask,
    input logic          bypass,
    input logic [CW-1:0] hi_cnt,
    input logic [CW-1:0] lo_cnt,
    input logic          rotating
);
    assert_clear_on_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (mask == '0) && !bypass);

    assert_count_choice_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mask != '0) |-> ($countones(mask) == int'(lo_cnt)) || ($countones(mask) == int'(hi_cnt)));

    assert_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt == lo_cnt) || ({1'b0, hi_cnt} == ({1'b0, lo_cnt} + 1'b1)));

    assert_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(hi_cnt) <= int'(N));

    assert_bypass_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en && bypass |=> bypass || !en);

    assert_hold_between_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en && !rotating |=> $stable(mask));
endmodule

bind cell_charge_rotator cell_charge_rotator_chk #(.N(N_CELLS), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(chg_en), .mask(insert_mask),
    .bypass(bypass_res), .hi_cnt(hi_q), .lo_cnt(lo_q), .rotating(rot_now)
);

// File: tb/cell_charge_rotator_test.sv
module cell_charge_rotator_test;
    localparam int TICK = 40;

    typedef struct packed {
        logic [15:0]  dc;
        logic [11:0]  tgt;
        logic [119:0] cells;
        logic [9:0]   mask;
        logic         byp;
    } vec_t;

    // Cell concatenations list cell 9 first, cell 0 last.
    localparam vec_t VECS [9] = '{
        '{16'd150, 12'd70, {10{12'd30}}, 10'h007, 1'b0},   // R2 high count, R5 ties
        '{16'd150, 12'd70, {10{12'd75}}, 10'h003, 1'b1},   // R2 low count, R7
        '{16'd150, 12'd50, {12'd35,12'd45,12'd25,12'd55,12'd30,12'd40,12'd10,12'd50,12'd20,12'd60},
          10'h08A, 1'b0},                                   // R3 exact, R5 lowest
        '{16'd2000, 12'd100, {10{12'd100}}, 10'h3FF, 1'b1}, // R4 clamp
        '{16'd150, 12'd200, {10{12'd210}}, 10'h000, 1'b1},  // R2 low count zero
        '{16'd150, 12'd200, {12'd99,12'd90,12'd80,12'd70,12'd40,12'd60,12'd40,12'd40,12'd40,12'd50},
          10'h002, 1'b0},                                   // R5 tie on index
        '{16'd150, 12'd70, {10{12'd63}}, 10'h007, 1'b1},    // R7 exact 90%
        '{16'd150, 12'd70, {10{12'd62}}, 10'h007, 1'b0},    // R7 just below
        '{16'd300, 12'd70, {12'd74,12'd73,12'd85,12'd95,12'd71,12'd72,12'd75,12'd90,12'd70,12'd80},
          10'h132, 1'b1}                                    // R2 floor, R5
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chg_en = 1'b0;
    logic [119:0]  v_cell = '0;
    logic [15:0]   v_pole = '0;
    logic [11:0]   v_target = 12'd1;
    logic [9:0]    insert_mask;
    logic          bypass_res;

    int checks = 0;
    int fails  = 0;
    int r6_viol = 0;
    int gap = 0;
    logic en_at_edge = 1'b0;
    logic [9:0] prev_mask = '0;

    always #4 clk = ~clk;

    cell_charge_rotator #(.CLK_HZ(40000), .TICK_HZ(1000)) uut (
        .clk(clk), .rst_n(rst_n), .chg_en(chg_en), .v_cell(v_cell),
        .v_pole(v_pole), .v_target(v_target),
        .insert_mask(insert_mask), .bypass_res(bypass_res)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2 * TICK + 10) @(posedge clk);
        @(negedge clk);
    endtask

    // R6 monitor: mask moves no sooner than half a tick period apart while enabled
    always @(posedge clk) en_at_edge <= chg_en;
    always @(negedge clk) begin
        if (!en_at_edge) gap = 0;
        else begin
            gap++;
            if (insert_mask != prev_mask) begin
                if (gap < TICK / 2) r6_viol++;
                gap = 0;
            end
        end
        prev_mask = insert_mask;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got hung expected done");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 mask in reset", 32'(insert_mask), 32'h0);
        check("R1 bypass in reset", 32'(bypass_res), 32'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 mask idle after reset", 32'(insert_mask), 32'h0);

        for (int k = 0; k < 9; k++) begin
            chg_en = 1'b0;
            repeat (3) @(negedge clk);
            v_pole   = VECS[k].dc;
            v_target = VECS[k].tgt;
            v_cell   = VECS[k].cells;
            @(negedge clk);
            chg_en = 1'b1;
            settle();
            check($sformatf("R2 R3 R4 R5 mask vector %0d", k), 32'(insert_mask), 32'(VECS[k].mask));
            check($sformatf("R7 bypass vector %0d", k), 32'(bypass_res), 32'(VECS[k].byp));
        end

        // R7 sticky bypass and R2 switch to high count within one run
        chg_en = 1'b0;
        repeat (3) @(negedge clk);
        v_pole = 16'd150; v_target = 12'd70; v_cell = {10{12'd75}};
        @(negedge clk);
        chg_en = 1'b1;
        settle();
        check("R2 low count before drop", 32'(insert_mask), 32'h003);
        v_cell = {10{12'd30}};
        settle();
        check("R2 high count after drop", 32'(insert_mask), 32'h007);
        check("R7 bypass stays high", 32'(bypass_res), 32'h1);

        // R9 pole change mid-run ignored (new value would give 5 cells)
        v_pole = 16'd300;
        settle();
        check("R9 count unchanged by pole", 32'(insert_mask), 32'h007);

        // R8 disable clears next edge
        chg_en = 1'b0;
        @(negedge clk);
        check("R8 mask cleared", 32'(insert_mask), 32'h0);
        check("R8 bypass cleared", 32'(bypass_res), 32'h0);
        repeat (2 * TICK) @(negedge clk);
        check("R8 stays idle", 32'(insert_mask), 32'h0);

        check("R6 mask change spacing", 32'(r6_viol), 32'h0);

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule